// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

A sixteen-line general-purpose I/O port controlled through a simple register bus that honours halfword accesses only. Software sets which lines are inputs and which are driven outputs, writes the values to drive, and chooses per line whether a rising or a falling input transition should be reported. Reported transitions land in a sticky status register that drives a single interrupt line. Software clears that register with a write-one-to-clear.

External pin levels are brought into the clock domain by a two-stage synchroniser. A transition is found by comparing the synchronised vector with its value one cycle earlier. Reads of the input data are gated per line by a pin-enable register, so disabled lines read as zero. Bus reads are combinational: the data is valid in the same cycle as the request.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset the input-data view and the status register read 0, and the output-data, direction, edge-select, mask and pin-enable registers read 0xFFFF. The interrupt is low and all output lines are 0.
- R2: Only accesses with `bus_size` = 1 (halfword) take effect. Sizes 0 (byte), 2 (word) and 3 change no register, and reads of those sizes return 0.
- R3: The input-data register (offset 0x00) returns the synchronised pin levels ANDed with the pin-enable register (offset 0x18). A pin change is visible in a read two clock edges after it is applied, and not after one.
- R4: Writes to the input-data offset and to offsets other than 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 change nothing. Reads of undefined offsets return 0.
- R5: Output line i equals bit i of the output-data register (0x04) when direction bit i (0x08) is 0, and is 0 when the direction bit is 1 (input).
- R6: Status bit i (0x14) is set when input i rises while its edge-select bit (0x0C) is 1, or falls while its edge-select bit is 0. The line must be an input and its mask bit (0x10) must be 0.
- R7: No status bit is set for a transition of the unselected polarity, for a line configured as an output, or for a line whose mask bit is 1.
- R8: Writing the status register clears each bit written as 1 and keeps each bit written as 0. A transition detected in the same cycle as a clear of that bit leaves the bit set.
- R9: The interrupt output is high exactly while any status bit is set. It stays high after a partial clear and drops only when every bit is clear.
- R10: The output-data, direction, edge-select, mask and pin-enable registers read back the last value written with a halfword access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the request cycle |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven output levels |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The assertions assume that pin levels are stable for at least two clock edges, so that the synchroniser output traces the pin vector delayed by two cycles. They also assume bus signals change only between edges, never on them. The stimulus drives both buses on the falling clock edge and holds each pin pattern for several cycles before the next change. A clear aimed at the same cycle as a detected transition is placed by counting edges from the pin change.

// File: rtl/egp_pkg.sv
// Package: shared constants for the edge-interrupt GPIO port.
// Holds the register offsets, the access-size encoding and the mapping from
// configuration-register index to its bus offset. Offsets are byte offsets.
package egp_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    localparam int unsigned OFF_DIN    = 32'h00;
    localparam int unsigned OFF_DOUT   = 32'h04;
    localparam int unsigned OFF_DIR    = 32'h08;
    localparam int unsigned OFF_EDGE   = 32'h0C;
    localparam int unsigned OFF_MASK   = 32'h10;
    localparam int unsigned OFF_STAT   = 32'h14;
    localparam int unsigned OFF_PINEN  = 32'h18;

    localparam int unsigned SYNC_STAGES = 2;

    // Configuration registers held in the register file, by index.
    localparam int unsigned CFG_DOUT  = 0;
    localparam int unsigned CFG_DIR   = 1;
    localparam int unsigned CFG_EDGE  = 2;
    localparam int unsigned CFG_MASK  = 3;
    localparam int unsigned CFG_PINEN = 4;
    localparam int unsigned CFG_COUNT = 5;

    // Bus offset of a configuration register given its index.
    function automatic int unsigned cfg_offset(input int unsigned idx);
        int unsigned off;
        case (idx)
            CFG_DOUT:  off = OFF_DOUT;
            CFG_DIR:   off = OFF_DIR;
            CFG_EDGE:  off = OFF_EDGE;
            CFG_MASK:  off = OFF_MASK;
            default:   off = OFF_PINEN;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/egp_sync.sv
// Module: egp_sync
// Multi-stage synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is sampled independently (no bus coherency needed) and
// that the reset value of every stage is 0.
module egp_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            // Later stages resolve metastability of the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/egp_regs.sv
// Module: egp_regs
// Register file and bus decode of the GPIO port. Holds the configuration
// registers, drives the output lines, forms the read data and produces the
// status-clear request. The status register itself lives in egp_edge.
// Assumes a single-cycle request: writes commit on the edge that samples
// bus_en, reads are combinational. Only halfword accesses are honoured.
module egp_regs
    import egp_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   sync_in,
    input  logic [PINS-1:0]   status_in,
    output logic [PINS-1:0]   dir_o,
    output logic [PINS-1:0]   edge_o,
    output logic [PINS-1:0]   mask_o,
    output logic [PINS-1:0]   pin_out,
    output logic              clr_en,
    output logic [PINS-1:0]   clr_bits
);

    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFF_DIN);
    localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(OFF_DOUT);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(OFF_EDGE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_PINEN = ADDR_W'(OFF_PINEN);
    localparam int unsigned       FLAT_W  = PINS * CFG_COUNT;

    logic              acc_ok;
    logic              wr_ok;
    logic              rd_ok;
    logic [PINS-1:0]   cfg_q [CFG_COUNT];
    logic [FLAT_W-1:0] cfg_flat;
    logic              cfg_hit;

    // Qualify the request: halfword size only.
    always_comb begin
        acc_ok = bus_en && (bus_size == ACC_HALF);
        wr_ok  = acc_ok && bus_we;
        rd_ok  = acc_ok && !bus_we;
    end

    // One register per configuration index, all reset to ones.
    for (genvar i = 0; i < CFG_COUNT; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(cfg_offset(i));
        always_ff @(posedge clk) begin
            if (!rst_n)                             cfg_q[i] <= '1;
            else if (wr_ok && (bus_addr == MY_OFF)) cfg_q[i] <= bus_wdata;
        end
    end

    // Flattened view used by the stability checks.
    always_comb begin
        for (int i = 0; i < CFG_COUNT; i++) begin
            cfg_flat[i*PINS +: PINS] = cfg_q[i];
        end
    end

    // Does the address name a writable configuration register.
    always_comb begin
        cfg_hit = 1'b0;
        for (int i = 0; i < CFG_COUNT; i++) begin
            if (bus_addr == ADDR_W'(cfg_offset(i))) cfg_hit = 1'b1;
        end
    end

    // Export the fields the edge logic and the pins need.
    always_comb begin
        dir_o   = cfg_q[CFG_DIR];
        edge_o  = cfg_q[CFG_EDGE];
        mask_o  = cfg_q[CFG_MASK];
        pin_out = cfg_q[CFG_DOUT] & ~cfg_q[CFG_DIR];
    end

    // Status clear request: write-one-to-clear at the status offset.
    always_comb begin
        clr_en   = wr_ok && (bus_addr == A_STAT);
        clr_bits = bus_wdata;
    end

    // Read multiplexer; anything not decoded returns zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_addr)
                A_DIN:   bus_rdata = sync_in & cfg_q[CFG_PINEN];
                A_DOUT:  bus_rdata = cfg_q[CFG_DOUT];
                A_DIR:   bus_rdata = cfg_q[CFG_DIR];
                A_EDGE:  bus_rdata = cfg_q[CFG_EDGE];
                A_MASK:  bus_rdata = cfg_q[CFG_MASK];
                A_STAT:  bus_rdata = status_in;
                A_PINEN: bus_rdata = cfg_q[CFG_PINEN];
                default: bus_rdata = '0;
            endcase
        end
    end

    // R2
    bad_size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && (bus_size != ACC_HALF)) |=> $stable(cfg_flat));

    // R4
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !cfg_hit) |=> $stable(cfg_flat));

endmodule

// File: rtl/egp_edge.sv
// Module: egp_edge
// Edge detection and sticky interrupt status. Compares the synchronised
// inputs with their previous sample, qualifies each transition by the
// polarity select, direction and mask, and accumulates it in the status
// register. A clear and a new event for the same bit in one cycle leave
// the bit set. Assumes sync_i is already in the clock domain.
module egp_edge #(
    parameter int unsigned PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] sync_i,
    input  logic [PINS-1:0] dir_i,
    input  logic [PINS-1:0] edge_sel_i,
    input  logic [PINS-1:0] mask_i,
    input  logic            clr_en,
    input  logic [PINS-1:0] clr_bits,
    output logic [PINS-1:0] status_q,
    output logic [PINS-1:0] evt
);

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] rise;
    logic [PINS-1:0] fall;
    logic [PINS-1:0] clr_vec;
    logic [PINS-1:0] status_d;

    // Remember last cycle's synchronised levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    // Per-bit transition detection and qualification.
    always_comb begin
        rise = sync_i & ~prev_q;
        fall = ~sync_i & prev_q;
        evt  = ((edge_sel_i & rise) | (~edge_sel_i & fall)) & dir_i & ~mask_i;
    end

    // Next status: clear requested bits, then let new events win.
    always_comb begin
        clr_vec  = clr_en ? clr_bits : '0;
        status_d = (status_q & ~clr_vec) | evt;
    end

    // Sticky status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R7
    set_needs_enabled_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~$past(status_q) & ($past(mask_i) | ~$past(dir_i))) == '0);

    // R8
    drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_q) & ~status_q) & ~({PINS{$past(clr_en)}} & $past(clr_bits))) == '0);

endmodule

// File: rtl/edge_gpio_port.sv
// Module: edge_gpio_port
// Top of the edge-interrupt GPIO port: synchroniser, register file and edge
// detector. Assumes pin_in is asynchronous and bus signals are synchronous
// to clk. The interrupt is the OR of the status bits.
module edge_gpio_port
    import egp_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic              irq
);

    logic [PINS-1:0] sync_v;
    logic [PINS-1:0] dir_v;
    logic [PINS-1:0] edge_v;
    logic [PINS-1:0] mask_v;
    logic [PINS-1:0] status_v;
    logic [PINS-1:0] evt_v;
    logic [PINS-1:0] clr_bits_v;
    logic            clr_en_v;
    logic [1:0]      warm_q;

    egp_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_v)
    );

    egp_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_v),
        .status_in (status_v),
        .dir_o     (dir_v),
        .edge_o    (edge_v),
        .mask_o    (mask_v),
        .pin_out   (pin_out),
        .clr_en    (clr_en_v),
        .clr_bits  (clr_bits_v)
    );

    egp_edge #(.PINS(PINS)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_v),
        .dir_i      (dir_v),
        .edge_sel_i (edge_v),
        .mask_i     (mask_v),
        .clr_en     (clr_en_v),
        .clr_bits   (clr_bits_v),
        .status_q   (status_v),
        .evt        (evt_v)
    );

    // Interrupt follows the presence of any pending status bit.
    always_comb irq = |status_v;

    // Cycles since reset, saturating, so the latency check looks back only
    // over cycles that exist.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R3
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_v == $past(pin_in, 2)));

    // R9
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|evt_v));

endmodule

// File: tb/edge_gpio_port_tb.sv
// Directed bench for edge_gpio_port. Inputs change on the falling edge;
// outputs are sampled on the falling edge as well.
module edge_gpio_port_tb;

    localparam logic [7:0] A_DIN   = 8'h00;
    localparam logic [7:0] A_DOUT  = 8'h04;
    localparam logic [7:0] A_DIR   = 8'h08;
    localparam logic [7:0] A_EDGE  = 8'h0C;
    localparam logic [7:0] A_MASK  = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_PINEN = 8'h18;
    localparam logic [1:0] SZ_B = 2'd0;
    localparam logic [1:0] SZ_H = 2'd1;
    localparam logic [1:0] SZ_W = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = SZ_H;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    edge_gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; commits on the next rising edge.
    task automatic bus_write(input logic [7:0] a, input logic [15:0] d,
                             input logic [1:0] sz);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_size = SZ_H;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [1:0] sz,
                            output logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        d = bus_rdata;
        bus_en = 1'b0; bus_size = SZ_H;
        #1;
    endtask

    task automatic read_chk(input string req, input string what,
                            input logic [7:0] a, input logic [1:0] sz,
                            input logic [15:0] exp);
        logic [15:0] d;
        bus_read(a, sz, d);
        check(req, what, d, exp);
    endtask

    task automatic t_reset;
        read_chk("R1", "din",    A_DIN,   SZ_H, 16'h0000);
        read_chk("R1", "dout",   A_DOUT,  SZ_H, 16'hFFFF);
        read_chk("R1", "dir",    A_DIR,   SZ_H, 16'hFFFF);
        read_chk("R1", "edge",   A_EDGE,  SZ_H, 16'hFFFF);
        read_chk("R1", "mask",   A_MASK,  SZ_H, 16'hFFFF);
        read_chk("R1", "status", A_STAT,  SZ_H, 16'h0000);
        read_chk("R1", "pinen",  A_PINEN, SZ_H, 16'hFFFF);
        check("R1", "irq", {15'd0, irq}, 16'h0000);
        check("R1", "pin_out", pin_out, 16'h0000);
    endtask

    task automatic t_outputs;
        bus_write(A_DIR, 16'hFF00, SZ_H);
        check("R5", "pin_out dir=FF00", pin_out, 16'h00FF);
        bus_write(A_DOUT, 16'h5A3C, SZ_H);
        check("R5", "pin_out dout=5A3C", pin_out, 16'h003C);
        read_chk("R10", "dout readback", A_DOUT, SZ_H, 16'h5A3C);
        read_chk("R10", "dir readback",  A_DIR,  SZ_H, 16'hFF00);
        bus_write(A_DIR, 16'hFFFF, SZ_H);
        check("R5", "pin_out all inputs", pin_out, 16'h0000);
    endtask

    task automatic t_datain;
        pin_in = 16'hA5C3;
        wait_clks(1);
        read_chk("R3", "din after 1 edge", A_DIN, SZ_H, 16'h0000);
        wait_clks(1);
        read_chk("R3", "din after 2 edges", A_DIN, SZ_H, 16'hA5C3);
        bus_write(A_PINEN, 16'h0F0F, SZ_H);
        read_chk("R3", "din gated", A_DIN, SZ_H, 16'h0503);
        read_chk("R10", "pinen readback", A_PINEN, SZ_H, 16'h0F0F);
        bus_write(A_PINEN, 16'hFFFF, SZ_H);
        read_chk("R7", "masked status", A_STAT, SZ_H, 16'h0000);
    endtask

    task automatic t_badaccess;
        bus_write(A_DOUT, 16'h1111, SZ_B);
        bus_write(A_DOUT, 16'h2222, SZ_W);
        read_chk("R2", "dout after bad sizes", A_DOUT, SZ_H, 16'h5A3C);
        read_chk("R2", "byte read", A_DOUT, SZ_B, 16'h0000);
        read_chk("R2", "word read", A_DIR, SZ_W, 16'h0000);
        check("R2", "pin_out unchanged", pin_out, 16'h0000);
    endtask

    task automatic t_undef;
        bus_write(A_DIN, 16'h0000, SZ_H);
        read_chk("R4", "din write ignored", A_DIN, SZ_H, 16'hA5C3);
        bus_write(8'h1C, 16'h0000, SZ_H);
        bus_write(8'h06, 16'h0000, SZ_H);
        read_chk("R4", "dout", A_DOUT, SZ_H, 16'h5A3C);
        read_chk("R4", "dir", A_DIR, SZ_H, 16'hFFFF);
        read_chk("R4", "edge", A_EDGE, SZ_H, 16'hFFFF);
        read_chk("R4", "mask", A_MASK, SZ_H, 16'hFFFF);
        read_chk("R4", "pinen", A_PINEN, SZ_H, 16'hFFFF);
        read_chk("R4", "undef read", 8'h1C, SZ_H, 16'h0000);
    endtask

    task automatic t_rise;
        pin_in = 16'h0000;
        wait_clks(3);
        bus_write(A_MASK, 16'h0000, SZ_H);
        read_chk("R10", "mask readback", A_MASK, SZ_H, 16'h0000);
        read_chk("R6", "no event yet", A_STAT, SZ_H, 16'h0000);
        pin_in = 16'h0021;
        wait_clks(3);
        read_chk("R6", "rising status", A_STAT, SZ_H, 16'h0021);
        check("R9", "irq after rise", {15'd0, irq}, 16'h0001);
        bus_write(A_STAT, 16'hFFFF, SZ_H);
        read_chk("R8", "cleared", A_STAT, SZ_H, 16'h0000);
        check("R9", "irq after full clear", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_fall;
        bus_write(A_EDGE, 16'hFFFE, SZ_H);
        read_chk("R10", "edge readback", A_EDGE, SZ_H, 16'hFFFE);
        pin_in = 16'h0020;
        wait_clks(3);
        read_chk("R6", "falling status", A_STAT, SZ_H, 16'h0001);
        bus_write(A_STAT, 16'h0001, SZ_H);
        read_chk("R8", "cleared", A_STAT, SZ_H, 16'h0000);
    endtask

    task automatic t_blocked;
        bus_write(A_MASK, 16'h0010, SZ_H);
        bus_write(A_DIR, 16'hFFBF, SZ_H);
        // bit5 falls (rise-select), bit4 rises (masked), bit6 rises (output)
        pin_in = 16'h0050;
        wait_clks(3);
        read_chk("R7", "blocked events", A_STAT, SZ_H, 16'h0000);
        check("R7", "irq stays low", {15'd0, irq}, 16'h0000);
        bus_write(A_MASK, 16'h0000, SZ_H);
        bus_write(A_DIR, 16'hFFFF, SZ_H);
        wait_clks(1);
        read_chk("R7", "no late event", A_STAT, SZ_H, 16'h0000);
    endtask

    task automatic t_clear;
        pin_in = 16'h0350;
        wait_clks(3);
        read_chk("R6", "two rises", A_STAT, SZ_H, 16'h0300);
        bus_write(A_STAT, 16'h0100, SZ_H);
        read_chk("R8", "partial clear", A_STAT, SZ_H, 16'h0200);
        check("R9", "irq after partial clear", {15'd0, irq}, 16'h0001);
        bus_write(A_STAT, 16'h0000, SZ_H);
        read_chk("R8", "zero write keeps", A_STAT, SZ_H, 16'h0200);
        bus_write(A_STAT, 16'h0200, SZ_H);
        read_chk("R8", "last clear", A_STAT, SZ_H, 16'h0000);
        check("R9", "irq low", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_race;
        pin_in = 16'h0750;
        wait_clks(2);
        // clear lands on the same edge as the bit10 event
        bus_write(A_STAT, 16'h0400, SZ_H);
        read_chk("R8", "event wins over clear", A_STAT, SZ_H, 16'h0400);
        check("R9", "irq on race", {15'd0, irq}, 16'h0001);
        bus_write(A_STAT, 16'h0400, SZ_H);
        read_chk("R8", "clear after race", A_STAT, SZ_H, 16'h0000);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(1);
        t_reset();
        t_outputs();
        t_datain();
        t_badaccess();
        t_undef();
        t_rise();
        t_fall();
        t_blocked();
        t_clear();
        t_race();
        wait_clks(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule